// File: doc/BRIEF.md
# Input protection switch sequencer

This block is the digital sequencer for a load switch that sits between an external supply connector and the system rail. It sees the input supply only through synchronous comparator results: under-voltage, over-voltage at the normal limit, over-voltage at a raised limit, and over-temperature. It also reads two active-low selection pins and a one-millisecond tick. From these it drives the pass-switch enable and an active-low fault flag, and it reports the decoded operating mode.

Once the input is fault-free, the switch closes after a programmable number of ticks. The flag is released after a second count of ticks, which starts when the switch closes. Any fault opens the switch and pulls the flag low on the next clock, with no timer involved. When the fault clears, the whole sequence runs again from zero. A thermal fault that keeps coming back therefore produces a repeating off/requalify/on cycle.

Top module: `inprot_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `sw_en` is 0 and `flag_n` is 0.
- R2: `mode_code` equals `{sel_a_n, sel_b_n}`. 2'b00 is enhance, 2'b01 is direct, 2'b10 is reverse and 2'b11 is disable.
- R3: In enhance, direct or reverse mode with no fault, `sw_en` rises at the clock edge that samples the ON_MS-th `ms_tick` counted since the last fault, reset or disable.
- R4: After `sw_en` rises in a non-disable mode, `flag_n` rises at the edge that samples the FLAG_MS-th later `ms_tick`. Until then it stays 0, including after a return from disable mode.
- R5: A fault opens the switch and drives `flag_n` low on the next edge. Any fault seen during either count restarts the count from zero.
- R6: Enhance mode treats `ov_hi_flt` as its over-voltage fault and ignores `ov_flt`. Direct and disable modes use `ov_flt` and ignore `ov_hi_flt`. `uv_flt` counts as a fault in all three modes.
- R7: In reverse mode, `uv_flt`, `ov_flt` and `ov_hi_flt` have no effect, and only `ot_flt` is a fault.
- R8: `ot_flt` is a fault in every mode. After it clears, the switch closes again after the full ON_MS delay, and the cycle repeats each time the fault returns.
- R9: In disable mode, `sw_en` is 0 from the next edge. `flag_n` then follows the absence of a fault on the next edge, with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| uv_flt | input | 1 | Input below under-voltage limit |
| ov_flt | input | 1 | Input above normal over-voltage limit |
| ov_hi_flt | input | 1 | Input above raised over-voltage limit |
| ot_flt | input | 1 | Die over-temperature |
| sel_a_n | input | 1 | Mode select, upper bit |
| sel_b_n | input | 1 | Mode select, lower bit |
| sw_en | output | 1 | Pass-switch enable |
| flag_n | output | 1 | Active-low fault flag |
| mode_code | output | 2 | Decoded mode |

## Verification
The bench builds the block with ON_MS=4 and FLAG_MS=3 and issues a tick every fourth clock. A full qualify-and-release sequence therefore takes a few dozen cycles. This lets the run cover every mode and fault, both with the switch closed and in the middle of each count. It also covers repeated thermal retries and the return from disable mode, all within a short run.

// File: rtl/inprot_seq.sv
module inprot_seq #(
  parameter int ON_MS   = 30,
  parameter int FLAG_MS = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       uv_flt,
  input  logic       ov_flt,
  input  logic       ov_hi_flt,
  input  logic       ot_flt,
  input  logic       sel_a_n,
  input  logic       sel_b_n,
  output logic       sw_en,
  output logic       flag_n,
  output logic [1:0] mode_code
);
  localparam int CMAX = (ON_MS > FLAG_MS) ? ON_MS : FLAG_MS;
  localparam int CW   = $clog2(CMAX + 1);

  logic [CW-1:0] cnt;
  logic m_enh, m_rev, m_dis, in_bad, fault;

  assign mode_code = {sel_a_n, sel_b_n};
  assign m_enh  = (mode_code == 2'b00);
  assign m_rev  = (mode_code == 2'b10);
  assign m_dis  = (mode_code == 2'b11);
  assign in_bad = !m_rev && (uv_flt || (m_enh ? ov_hi_flt : ov_flt));
  assign fault  = in_bad || ot_flt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_en  <= 1'b0;
      flag_n <= 1'b0;
      cnt    <= '0;
    end else if (fault || m_dis) begin
      sw_en  <= 1'b0;
      flag_n <= m_dis && !fault;
      cnt    <= '0;
    end else if (!sw_en) begin
      flag_n <= 1'b0;
      if (ms_tick) begin
        if (cnt == CW'(ON_MS - 1)) begin
          sw_en <= 1'b1;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end else if (!flag_n && ms_tick) begin
      if (cnt == CW'(FLAG_MS - 1)) begin
        flag_n <= 1'b1;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R5
  fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!sw_en && !flag_n));
  // R9
  dis_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_dis |=> !sw_en);
  // R3
  close_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_en) |-> $past(ms_tick));
  // R4
  flag_after_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_n) |-> (sw_en || $past(m_dis)));
  // R7
  rev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rev && !ot_flt && sw_en) |=> sw_en);
endmodule

// File: tb/inprot_seq_tb.sv
module inprot_seq_tb_top;
  localparam int ON = 4;
  localparam int FL = 3;

  logic clk = 0, rst_n = 0, ms_tick = 0;
  logic uv = 0, ov = 0, ovh = 0, ot = 0, sa = 0, sb = 1;
  logic sw_en, flag_n;
  logic [1:0] mode_code;
  int checks = 0, failures = 0;
  int tdiv = 0;
  int m_sw = 0, m_flag = 0, good_ticks = 0, up_ticks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  inprot_seq #(.ON_MS(ON), .FLAG_MS(FL)) dut_i (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .uv_flt(uv), .ov_flt(ov),
    .ov_hi_flt(ovh), .ot_flt(ot), .sel_a_n(sa), .sel_b_n(sb),
    .sw_en(sw_en), .flag_n(flag_n), .mode_code(mode_code));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    tdiv = (tdiv + 1) % 4;
    ms_tick = (tdiv == 0);
  end

  // behavioural reference
  always @(posedge clk) begin
    int md;
    bit bad, dis;
    md  = {sa, sb};
    dis = (md == 3);
    case (md)
      0: bad = uv || ovh || ot;
      2: bad = ot;
      default: bad = uv || ov || ot;
    endcase
    if (!rst_n) begin
      m_sw = 0; m_flag = 0; good_ticks = 0; up_ticks = 0;
    end else if (bad || dis) begin
      m_sw = 0; m_flag = (dis && !bad); good_ticks = 0; up_ticks = 0;
    end else if (m_sw == 0) begin
      m_flag = 0; up_ticks = 0;
      if (ms_tick) begin
        good_ticks++;
        if (good_ticks == ON) m_sw = 1;
      end
    end else if (m_flag == 0 && ms_tick) begin
      up_ticks++;
      if (up_ticks == FL) m_flag = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(({sa, sb} == 3) ? "R9" : "R3", sw_en, m_sw);
      chk(({sa, sb} == 3) ? "R9" : "R4", flag_n, m_flag);
      chk("R2", mode_code, {sa, sb});
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(3);
    chk("R1", sw_en, 0);
    chk("R1", flag_n, 0);
    rst_n = 1;
    step(1);
    chk("R1", sw_en, 0);
    // direct mode power-up
    step(60);
    chk("R3", sw_en, 1);
    chk("R4", flag_n, 1);
    // normal over-voltage trips
    ov = 1; step(1);
    chk("R5", sw_en, 0);
    chk("R5", flag_n, 0);
    ov = 0; step(6);
    uv = 1; step(2); uv = 0;   // mid-count glitch restarts
    step(60);
    chk("R5", sw_en, 1);
    // enhance mode: only raised limit counts
    sb = 0; ov = 1; step(60);
    chk("R6", sw_en, 1);
    chk("R6", flag_n, 1);
    ovh = 1; step(1);
    chk("R6", sw_en, 0);
    ovh = 0; ov = 0;
    // direct mode ignores raised limit
    sb = 1; ovh = 1; step(60);
    chk("R6", sw_en, 1);
    ovh = 0;
    // disable mode
    sa = 1; sb = 1; step(1);
    chk("R9", sw_en, 0);
    chk("R9", flag_n, 1);
    uv = 1; step(1);
    chk("R9", flag_n, 0);
    uv = 0; step(1);
    chk("R9", flag_n, 1);
    // back to direct: flag drops until requalified
    sa = 0; step(1);
    chk("R4", flag_n, 0);
    step(60);
    chk("R4", flag_n, 1);
    // reverse mode ignores input comparators
    sa = 1; sb = 0; uv = 1; ov = 1; ovh = 1; step(60);
    chk("R7", sw_en, 1);
    chk("R7", flag_n, 1);
    // thermal retry, twice
    for (int k = 0; k < 2; k++) begin
      ot = 1; step(5);
      chk("R8", sw_en, 0);
      chk("R8", flag_n, 0);
      ot = 0; step(2);
      chk("R8", sw_en, 0);
      step(60);
      chk("R8", sw_en, 1);
    end
    uv = 0; ov = 0; ovh = 0;
    step(5);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule